// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block runs a 32K x 8 asynchronous static RAM with a shared bidirectional data bus from a synchronous clock domain. A host hands it one request at a time over a valid/ready port (address, write data, a write/read select). The controller turns each request into a strobe sequence on the active-low chip enable, output enable and write enable pins. It holds the address and write data at the pins for the whole cycle and returns read data with a one-cycle valid pulse.

All timing comes from clock-cycle counts set by parameters: setup before the write strobe, the write strobe width, hold after the strobe, the read access length and an idle turnaround after a read. The defaults are 1, 2, 1, 2 and 1 cycles at a 100 MHz clock. With these, the strobe is at least 20 ns, data and address lead the strobe's rising edge by at least 30 ns, and read data is sampled 20 ns after output enable falls. The data pad is split into a value, a drive enable for the FPGA's own drivers and an input, so a pad cell or the board level can form the tri-state bus. Between requests the chip enable is high and the memory sits in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: When no request is in progress, req_ready is 1, mem_ce_n, mem_oe_n and mem_we_n are 1 and mem_dq_oe is 0, so the memory is in standby with its bus released.
- R3: A write (req_write=1) accepted at a clock edge is followed by SETUP_CYC cycles with mem_ce_n=0, mem_we_n=1 and mem_dq_oe=1. Then come exactly STROBE_CYC cycles with mem_we_n=0, then HOLD_CYC cycles with mem_we_n=1, mem_ce_n=0 and mem_dq_oe=1. mem_oe_n stays 1 throughout, and the memory stores the word when mem_we_n rises.
- R4: The address and write data are taken at acceptance. mem_addr, and mem_dq_out during a write, hold those values for the whole cycle, whatever the host inputs do after acceptance.
- R5: A read (req_write=0) accepted at a clock edge is followed by exactly ACCESS_CYC cycles with mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0.
- R6: rsp_rdata takes mem_dq_in at the clock edge that ends the last output-enable-low cycle. rsp_valid is 1 for exactly the one cycle after that edge.
- R7: After a read, TURN_CYC cycles with all strobes 1 and mem_dq_oe=0 pass before req_ready returns. mem_dq_oe is never 1 while mem_oe_n is 0, and it rises only after at least TURN_CYC cycles with mem_oe_n high, so the two sides never drive the bus together.
- R8: req_ready is 0 from the acceptance edge until the request completes. It returns SETUP_CYC+STROBE_CYC+HOLD_CYC cycles after a write is accepted, and ACCESS_CYC+TURN_CYC cycles after a read is accepted.
- R9: mem_oe_n and mem_we_n are never 0 together, and either is 0 only while mem_ce_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host presents a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Data to store on a write |
| req_ready | output | 1 | Controller idle; a request with req_valid is taken at the next edge |
| rsp_valid | output | 1 | One-cycle pulse marking rsp_rdata as valid |
| rsp_rdata | output | 8 | Word returned by the last read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address pins |
| mem_dq_out | output | 8 | Value driven onto the shared data bus |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Value seen on the shared data bus |

## Verification
Every pin result is registered once after the acceptance edge, so cycle k of a request (k = 0 just after acceptance) carries that phase's strobes. The bench checks each of those cycles at the falling clock edge against the phase the cycle counts give. Read data is due in cycle ACCESS_CYC after a read is accepted. The bench's memory model presents its word at the falling edge of each output-enable-low cycle, which puts it ahead of the capturing edge. req_ready is checked in the cycle the R8 formula names and in every busy cycle before it. A model write is checked only after the cycle in which write enable rose.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the asynchronous SRAM controller.
// Assumes: one request in flight at a time; every phase lasts at least one cycle.
package sram_ctrl_pkg;

    // Phase of a memory cycle; the order has no meaning to the pins.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_ACCESS = 3'd4,
        PH_TURN   = 3'd5
    } phase_e;

    // Chip is selected in every phase of a cycle except the read turnaround.
    function automatic logic phase_selects(input phase_e ph);
        return (ph == PH_SETUP) || (ph == PH_STROBE) ||
               (ph == PH_HOLD)  || (ph == PH_ACCESS);
    endfunction

    // Controller drives the data bus only in the phases of a write.
    function automatic logic phase_drives(input phase_e ph);
        return (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
    endfunction

    // Largest of five cycle counts, used to size the phase counter.
    function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d,
                                         input int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
// Phase sequencer: walks a write through setup, strobe and hold, and a read
// through access and turnaround. Each phase lasts its parameter's cycle count.
// Assumes: every count is at least 1; start is only raised while idle.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned STROBE_CYC = 2,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned ACCESS_CYC = 2,
    parameter int unsigned TURN_CYC   = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_write,
    output phase_e phase,
    output phase_e phase_nxt,
    output logic   capture
);

    localparam int unsigned MAX_LEN = max5(SETUP_CYC, STROBE_CYC, HOLD_CYC,
                                           ACCESS_CYC, TURN_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] last_cnt;
    logic             phase_done;

    // Select the length of the current phase, as its final counter value.
    always_comb begin
        case (phase_q)
            PH_SETUP:  last_cnt = CNT_W'(SETUP_CYC - 1);
            PH_STROBE: last_cnt = CNT_W'(STROBE_CYC - 1);
            PH_HOLD:   last_cnt = CNT_W'(HOLD_CYC - 1);
            PH_ACCESS: last_cnt = CNT_W'(ACCESS_CYC - 1);
            PH_TURN:   last_cnt = CNT_W'(TURN_CYC - 1);
            default:   last_cnt = '0;
        endcase
    end

    assign phase_done = (cnt_q == last_cnt);

    // Decide the next phase and the next counter value.
    always_comb begin
        phase_nxt = phase_q;
        cnt_nxt   = cnt_q + 1'b1;
        case (phase_q)
            PH_IDLE: begin
                cnt_nxt = '0;
                if (start) phase_nxt = start_write ? PH_SETUP : PH_ACCESS;
            end
            PH_SETUP:  if (phase_done) phase_nxt = PH_STROBE;
            PH_STROBE: if (phase_done) phase_nxt = PH_HOLD;
            PH_HOLD:   if (phase_done) phase_nxt = PH_IDLE;
            PH_ACCESS: if (phase_done) phase_nxt = PH_TURN;
            PH_TURN:   if (phase_done) phase_nxt = PH_IDLE;
            default:   phase_nxt = PH_IDLE;
        endcase
        if (phase_nxt != phase_q) cnt_nxt = '0;
    end

    // Advance phase and counter; reset returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    assign phase   = phase_q;
    assign capture = (phase_q == PH_ACCESS) && phase_done;

endmodule

// File: rtl/sram_ctrl_pins.sv
// Pin stage: registers the memory strobes and the bus drive enable from the
// next phase, so every pin comes straight from a flop and cannot glitch.
// Assumes: phase_nxt is the value the sequencer loads at this edge.
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_nxt,
    output logic   ce_n,
    output logic   oe_n,
    output logic   we_n,
    output logic   dq_oe,
    output logic   ready
);

    // Load each pin with its value for the coming phase; reset releases all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            ready <= 1'b1;
        end else begin
            ce_n  <= !phase_selects(phase_nxt);
            oe_n  <= (phase_nxt != PH_ACCESS);
            we_n  <= (phase_nxt != PH_STROBE);
            dq_oe <= phase_drives(phase_nxt);
            ready <= (phase_nxt == PH_IDLE);
        end
    end

endmodule

// File: rtl/sram_ctrl_dpath.sv
// Data path: holds the request address and write data for the whole memory
// cycle and captures the read word into a response register.
// Assumes: take is high only at the edge that accepts a request.
module sram_ctrl_dpath #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] pin_addr,
    output logic [DATA_W-1:0] pin_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Latch address and write data when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    // Capture the bus at the end of a read and pulse the valid flag once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= bus_in;
        end
    end

    assign pin_addr  = addr_q;
    assign pin_wdata = wdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
// Asynchronous SRAM controller top: host valid/ready request port on one side,
// active-low strobes, address and a split data pad on the other.
// Assumes: the memory's access, strobe and release times fit the parameter
// cycle counts at the clock in use; all counts are at least 1.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 15,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned STROBE_CYC = 2,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned ACCESS_CYC = 2,
    parameter int unsigned TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    phase_e phase;
    phase_e phase_nxt;
    logic   accept;
    logic   capture;

    // A request is taken at the edge where it meets an idle controller.
    assign accept = req_valid && (phase == PH_IDLE);

    sram_ctrl_seq #(
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .ACCESS_CYC(ACCESS_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_write(req_write),
        .phase      (phase),
        .phase_nxt  (phase_nxt),
        .capture    (capture)
    );

    sram_ctrl_pins u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_nxt(phase_nxt),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .dq_oe    (mem_dq_oe),
        .ready    (req_ready)
    );

    sram_ctrl_dpath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .host_addr (req_addr),
        .host_wdata(req_wdata),
        .capture   (capture),
        .bus_in    (mem_dq_in),
        .pin_addr  (mem_addr),
        .pin_wdata (mem_dq_out),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
// Protocol checker for the SRAM controller pins, bound to the top module.
// Assumes: synchronous active-low reset; counters saturate, so long idles are safe.
module sram_ctrl_chk #(
    parameter int unsigned ADDR_W     = 15,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned STROBE_CYC = 2,
    parameter int unsigned TURN_CYC   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    localparam int unsigned RUN_W = 16;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] we_run;
    logic [RUN_W-1:0] gap_run;

    // Count consecutive write-strobe-low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                          we_run <= '0;
        else if (mem_we_n)                   we_run <= '0;
        else if (we_run != RUN_MAX)          we_run <= we_run + 1'b1;
    end

    // Count released-bus cycles since output enable was last low.
    always_ff @(posedge clk) begin
        if (!rst_n)                              gap_run <= RUN_MAX;
        else if (!mem_oe_n)                      gap_run <= '0;
        else if (!mem_dq_oe && gap_run != RUN_MAX) gap_run <= gap_run + 1'b1;
    end

    p_idle_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == RUN_W'(STROBE_CYC)));

    p_write_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_data_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    p_read_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (gap_run >= RUN_W'(TURN_CYC)));

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

    p_strobe_needs_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> !mem_ce_n);

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STROBE_CYC(STROBE_CYC),
    .TURN_CYC  (TURN_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
// Bench: drives requests, models the memory from its read/write/standby table,
// and checks every pin cycle by cycle against the phase counts.
module tb_sram_async_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int S  = 1;
    localparam int W  = 2;
    localparam int H  = 1;
    localparam int RD = 2;
    localparam int T  = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    int errs = 0;
    int checks = 0;
    int clashes = 0;
    logic [DW-1:0] model [int];

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .STROBE_CYC(W),
        .HOLD_CYC(H), .ACCESS_CYC(RD), .TURN_CYC(T)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: drives the bus when selected, output-enabled and not writing.
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            mem_dq_in <= model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00;
            if (mem_dq_oe) clashes++;
        end else begin
            mem_dq_in <= mem_dq_oe ? mem_dq_out : 8'h00;
        end
    end

    // Model stores on the rising write strobe while selected.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) model[int'(mem_addr)] = mem_dq_out;
    end

    // Model stores when chip enable rises first during a write strobe.
    always @(posedge mem_ce_n) begin
        if (rst_n && !mem_we_n) model[int'(mem_addr)] = mem_dq_out;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pins();
        return {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
    endfunction

    // Issue a write at the next idle cycle and check every cycle of it.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int exp_p;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        for (int c = 0; c < S + W + H; c++) begin
            exp_p = (c >= S && c < S + W) ? 4'b0101 : 4'b0111;
            chk(pins() == exp_p, "R3 write strobes", pins(), exp_p);
            chk(mem_addr == a && mem_dq_out == d, "R4 write addr/data held",
                {mem_addr, mem_dq_out}, {a, d});
            chk(!req_ready, "R8 busy during write", req_ready, 0);
            @(negedge clk);
        end
        chk(req_ready && pins() == 4'b1110, "R8 R2 ready after write",
            {req_ready, pins()}, 5'b11110);
        chk(model.exists(int'(a)) && model[int'(a)] == d, "R3 memory stored",
            model.exists(int'(a)) ? model[int'(a)] : -1, d);
    endtask

    // Issue a read at the next idle cycle and check every cycle and the data.
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h5a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        for (int c = 0; c < RD; c++) begin
            chk(pins() == 4'b0010, "R5 read strobes", pins(), 4'b0010);
            chk(mem_addr == a, "R4 read addr held", mem_addr, a);
            chk(!rsp_valid && !req_ready, "R6 R8 no early response",
                {rsp_valid, req_ready}, 0);
            @(negedge clk);
        end
        chk(rsp_valid && rsp_rdata == e, "R6 read data", {rsp_valid, rsp_rdata},
            {1'b1, e});
        for (int c = RD; c < RD + T; c++) begin
            chk(pins() == 4'b1110 && !req_ready, "R7 turnaround released",
                {req_ready, pins()}, 5'b01110);
            if (c > RD) chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);
            @(negedge clk);
        end
        chk(req_ready && !rsp_valid, "R8 ready after read",
            {req_ready, rsp_valid}, 2'b10);
    endtask

    function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a, input int i);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'(i * 37);
    endfunction

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        repeat (2) @(negedge clk);
        chk(pins() == 4'b1110 && req_ready && !rsp_valid, "R1 reset state",
            {req_ready, rsp_valid, pins()}, 6'b101110);
        req_valid = 1'b1;
        @(negedge clk);
        chk(pins() == 4'b1110, "R1 request ignored in reset", pins(), 4'b1110);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(pins() == 4'b1110 && req_ready, "R1 first cycle after reset",
            {req_ready, pins()}, 5'b11110);
        repeat (3) @(negedge clk);
        chk(pins() == 4'b1110 && req_ready, "R2 idle standby",
            {req_ready, pins()}, 5'b11110);

        // Boundary addresses.
        do_write(15'h0000, 8'hA5);
        do_write(15'h7fff, 8'h3C);
        do_read(15'h0000, 8'hA5);
        do_read(15'h7fff, 8'h3C);

        // Sweep writes over spread addresses, then read them all back.
        for (int i = 0; i < 256; i++) begin
            a = AW'(i * 129 + 1);
            do_write(a, pattern(a, i));
        end
        for (int i = 0; i < 256; i++) begin
            a = AW'(i * 129 + 1);
            do_read(a, pattern(a, i));
        end

        // Alternating write and read on neighbouring words, read-to-write turnarounds.
        for (int i = 0; i < 64; i++) begin
            a = AW'(i * 511);
            do_write(a, 8'(255 - i));
            do_read(a, 8'(255 - i));
            do_read(AW'(i * 129 + 1), pattern(AW'(i * 129 + 1), i));
        end

        repeat (2) @(negedge clk);
        chk(clashes == 0, "R7 no bus contention", clashes, 0);
        chk(pins() == 4'b1110 && req_ready, "R2 standby at end",
            {req_ready, pins()}, 5'b11110);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule